// File: doc/BRIEF.md
# Bootstrap Copy Engine

The block keeps a short boot program in a 1 KB local memory that is never reset. On request it copies that program into a processor instruction memory, one 32-bit word per clock. Software loads the memory and three copy parameters through a register port: the source byte offset in the local memory, the destination byte address in instruction memory, and the length in words. It then starts the copy by setting a self-clearing go bit. Software can poll the go bit or a done flag in the status word to learn when the copy has finished.

Software can also arm the engine. While it is armed, every power-up event pulse replays the programmed copy, so the boot program returns to instruction memory after each sleep without software action. The block also holds four plain 32-bit registers: a pointer and a size for a program image and for a data image in host memory. Firmware reads these back. Bit 31 of the program-size register drives a load-request output.

Top module: `boot_copy_engine`

## Requirements
- R1: A write to offset 0x000 with bit 31 set, while the engine is idle and the word count at 0x00C is N > 0, causes exactly N instruction-memory writes on N consecutive cycles. Write k (counting from 0) presents local word ((src/4 + k) mod 256) at address (dst + 4k) mod 2^IMEM_AW. Write k is presented in the cycle that starts k+1 clock edges after the edge that accepted the start.
- R2: Bit 31 of a read of offset 0x000 returns 1 from the start edge until the edge after the last write, N+1 edges in total. After that it returns 0. Bit 30 of the same read returns the arm bit.
- R3: Bit 0 of the status word at offset 0x010 is cleared when a copy starts and is set on the edge that ends it.
- R4: A start with a word count of 0 sets the done flag on the start edge, leaves the go bit at 0, and makes no instruction-memory writes.
- R5: Writing bit 30 of offset 0x000 arms the engine. While it is armed, each pulse on `pwr_up` seen at an idle clock edge starts the programmed copy, with the same timing as R1. While it is disarmed, `pwr_up` has no effect.
- R6: A `pwr_up` pulse or a start write that arrives while a copy is running is dropped, so no further copy follows.
- R7: Writes to source (0x004), destination (0x008) and count (0x00C) are ignored while a copy is running and are accepted when the engine is idle. Each reads back zero-extended.
- R8: Byte offsets 0x400 to 0x7FF read and write the local memory one word at a time, and its contents survive reset.
- R9: Offsets 0x090, 0x094, 0x098 and 0x09C hold the program-image pointer, the program-image size, the data-image pointer and the data-image size as 32-bit values. `load_req` follows bit 31 of the program-image size.
- R10: Reset clears the go bit, the arm bit, the done flag and all parameter registers, so a `pwr_up` pulse after reset starts nothing.
- R11: A read asserted on `host_rd` at a clock edge places its data on `host_rdata` after that edge, and the data holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_wr | input | 1 | Register or memory write strobe |
| host_rd | input | 1 | Register or memory read strobe |
| host_addr | input | 12 | Byte address of the access |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, one cycle after `host_rd` |
| pwr_up | input | 1 | Power-up event pulse |
| imem_we | output | 1 | Instruction-memory write enable |
| imem_addr | output | IMEM_AW | Instruction-memory byte address |
| imem_wdata | output | 32 | Instruction-memory write data |
| load_req | output | 1 | Program load request flag |

## Verification
With the start edge E0, instruction write k must appear in the cycle after edge E(k+1), and the go bit and done flag must change on edge E(N+1). The bench counts negative edges from the start write. It logs each instruction write together with its cycle number and compares that number against the expected one. It issues register reads so that one read samples the last edge before completion and the next read samples the edge after it. Because reads return data one edge after `host_rd`, every read is checked at the negative edge that follows its request.

// File: rtl/boot_copy_pkg.sv
package boot_copy_pkg;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned WORD_W = 32;

    // Register offsets (byte addresses on the host port)
    localparam logic [ADDR_W-1:0] OFS_CTRL = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_SRC  = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_DST  = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_STAT = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_IPTR = 12'h090;
    localparam logic [ADDR_W-1:0] OFS_ISZ  = 12'h094;
    localparam logic [ADDR_W-1:0] OFS_DPTR = 12'h098;
    localparam logic [ADDR_W-1:0] OFS_DSZ  = 12'h09C;

    localparam int unsigned BIT_GO      = 31;
    localparam int unsigned BIT_ARM     = 30;
    localparam int unsigned BIT_LOADREQ = 31;
endpackage

// File: rtl/boot_copy_sram.sv
module boot_copy_sram #(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned DW    = 32,
    localparam int unsigned IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          h_we,
    input  logic          h_re,
    input  logic [IW-1:0] h_idx,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_rdata,
    input  logic          e_re,
    input  logic [IW-1:0] e_idx,
    output logic [DW-1:0] e_rdata
);
    typedef struct packed {
        logic [DW-1:0] h_out;
        logic [DW-1:0] e_out;
    } rd_t;

    logic [DW-1:0] store [DEPTH];
    rd_t rd_d, rd_q;

    // Contents carry no reset: they must survive it.
    always_ff @(posedge clk) begin
        if (h_we) store[h_idx] <= h_wdata;
    end

    always_comb begin
        rd_d = rd_q;
        if (h_re) rd_d.h_out = store[h_idx];
        if (e_re) rd_d.e_out = store[e_idx];
    end

    always_ff @(posedge clk) begin
        rd_q <= rd_d;
    end

    assign h_rdata = rd_q.h_out;
    assign e_rdata = rd_q.e_out;
endmodule

// File: rtl/boot_copy_regs.sv
module boot_copy_regs
    import boot_copy_pkg::*;
#(
    parameter int unsigned SRC_W    = 10,
    parameter int unsigned DST_W    = 16,
    parameter int unsigned CNT_W    = 9,
    parameter int unsigned MEM_BASE = 32'h400,
    parameter int unsigned MEM_SIZE = 1024,
    localparam int unsigned MEM_LIM = MEM_BASE + MEM_SIZE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              pwr_up,
    input  logic              eng_busy,
    input  logic              eng_done,
    output logic              mem_hit,
    output logic              start_req,
    output logic [SRC_W-1:0]  src,
    output logic [DST_W-1:0]  dst,
    output logic [CNT_W-1:0]  cnt,
    output logic              load_req,
    output logic [WORD_W-1:0] rd_word,
    output logic              rd_from_mem
);
    typedef struct packed {
        logic              arm;
        logic [SRC_W-1:0]  src;
        logic [DST_W-1:0]  dst;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] iptr;
        logic [WORD_W-1:0] isz;
        logic [WORD_W-1:0] dptr;
        logic [WORD_W-1:0] dsz;
        logic [WORD_W-1:0] rdata;
        logic              rd_mem;
    } regs_t;

    regs_t r_d, r_q;
    logic [WORD_W-1:0] view;
    logic              reg_wr;

    always_comb begin
        mem_hit = (32'(host_addr) >= MEM_BASE) && (32'(host_addr) < MEM_LIM);
        reg_wr  = host_wr && !mem_hit;

        case (host_addr)
            OFS_CTRL: begin
                view          = '0;
                view[BIT_GO]  = eng_busy;
                view[BIT_ARM] = r_q.arm;
            end
            OFS_SRC:  view = WORD_W'(r_q.src);
            OFS_DST:  view = WORD_W'(r_q.dst);
            OFS_CNT:  view = WORD_W'(r_q.cnt);
            OFS_STAT: view = WORD_W'(eng_done);
            OFS_IPTR: view = r_q.iptr;
            OFS_ISZ:  view = r_q.isz;
            OFS_DPTR: view = r_q.dptr;
            OFS_DSZ:  view = r_q.dsz;
            default:  view = '0;
        endcase

        r_d = r_q;
        if (reg_wr) begin
            case (host_addr)
                OFS_CTRL: r_d.arm = host_wdata[BIT_ARM];
                OFS_SRC:  if (!eng_busy) r_d.src = host_wdata[SRC_W-1:0];
                OFS_DST:  if (!eng_busy) r_d.dst = host_wdata[DST_W-1:0];
                OFS_CNT:  if (!eng_busy) r_d.cnt = host_wdata[CNT_W-1:0];
                OFS_IPTR: r_d.iptr = host_wdata;
                OFS_ISZ:  r_d.isz  = host_wdata;
                OFS_DPTR: r_d.dptr = host_wdata;
                OFS_DSZ:  r_d.dsz  = host_wdata;
                default:  ;
            endcase
        end
        if (host_rd) begin
            r_d.rd_mem = mem_hit;
            r_d.rdata  = view;
        end

        start_req = (reg_wr && (host_addr == OFS_CTRL) && host_wdata[BIT_GO])
                  || (r_q.arm && pwr_up);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign src         = r_q.src;
    assign dst         = r_q.dst;
    assign cnt         = r_q.cnt;
    assign load_req    = r_q.isz[BIT_LOADREQ];
    assign rd_word     = r_q.rdata;
    assign rd_from_mem = r_q.rd_mem;
endmodule

// File: rtl/boot_copy_mover.sv
module boot_copy_mover #(
    parameter int unsigned MEM_IW = 8,
    parameter int unsigned DST_W  = 16,
    parameter int unsigned CNT_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic [MEM_IW-1:0] src_idx,
    input  logic [DST_W-1:0]  dst,
    input  logic [CNT_W-1:0]  cnt,
    output logic              busy,
    output logic              done,
    output logic              rd_en,
    output logic [MEM_IW-1:0] rd_idx,
    output logic              imem_we,
    output logic [DST_W-1:0]  imem_addr
);
    typedef struct packed {
        logic              busy;
        logic              done;
        logic [MEM_IW-1:0] rd_ptr;
        logic [CNT_W-1:0]  left;
        logic              pend;
        logic [DST_W-1:0]  wa;
        logic [DST_W-1:0]  nxt;
    } mv_t;

    mv_t m_d, m_q;
    logic issue;

    always_comb begin
        m_d   = m_q;
        issue = m_q.busy && (m_q.left != '0);

        // stage 1: read local word; stage 2: write it out
        m_d.pend = issue;
        if (issue) begin
            m_d.rd_ptr = m_q.rd_ptr + MEM_IW'(1);
            m_d.left   = m_q.left - CNT_W'(1);
            m_d.wa     = m_q.nxt;
            m_d.nxt    = m_q.nxt + DST_W'(4);
        end

        if (m_q.busy && m_q.pend && (m_q.left == '0)) begin
            m_d.busy = 1'b0;
            m_d.done = 1'b1;
        end

        // requests while busy are dropped
        if (!m_q.busy && start_req) begin
            if (cnt == '0) begin
                m_d.done = 1'b1;
            end else begin
                m_d.busy   = 1'b1;
                m_d.done   = 1'b0;
                m_d.rd_ptr = src_idx;
                m_d.left   = cnt;
                m_d.nxt    = dst;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign busy      = m_q.busy;
    assign done      = m_q.done;
    assign rd_en     = issue;
    assign rd_idx    = m_q.rd_ptr;
    assign imem_we   = m_q.pend;
    assign imem_addr = m_q.wa;
endmodule

// File: rtl/boot_copy_engine.sv
module boot_copy_engine
    import boot_copy_pkg::*;
#(
    parameter int unsigned MEM_BYTES = 1024,
    parameter int unsigned MEM_BASE  = 32'h400,
    parameter int unsigned IMEM_AW   = 16,
    parameter int unsigned CNT_W     = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [11:0]        host_addr,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    input  logic               pwr_up,
    output logic               imem_we,
    output logic [IMEM_AW-1:0] imem_addr,
    output logic [31:0]        imem_wdata,
    output logic               load_req
);
    localparam int unsigned MEM_DEPTH = MEM_BYTES / 4;
    localparam int unsigned MEM_IW    = $clog2(MEM_DEPTH);
    localparam int unsigned SRC_W     = $clog2(MEM_BYTES);

    logic               mem_hit, start_req, busy_w, done_w, rd_en, rd_from_mem;
    logic [SRC_W-1:0]   src_w;
    logic [IMEM_AW-1:0] dst_w;
    logic [CNT_W-1:0]   cnt_w;
    logic [MEM_IW-1:0]  rd_idx;
    logic [WORD_W-1:0]  rd_word, mem_h_out;

    boot_copy_regs #(
        .SRC_W(SRC_W), .DST_W(IMEM_AW), .CNT_W(CNT_W),
        .MEM_BASE(MEM_BASE), .MEM_SIZE(MEM_BYTES)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .pwr_up(pwr_up), .eng_busy(busy_w), .eng_done(done_w),
        .mem_hit(mem_hit), .start_req(start_req),
        .src(src_w), .dst(dst_w), .cnt(cnt_w),
        .load_req(load_req), .rd_word(rd_word), .rd_from_mem(rd_from_mem)
    );

    boot_copy_mover #(
        .MEM_IW(MEM_IW), .DST_W(IMEM_AW), .CNT_W(CNT_W)
    ) u_mover (
        .clk(clk), .rst_n(rst_n),
        .start_req(start_req), .src_idx(src_w[SRC_W-1:2]),
        .dst(dst_w), .cnt(cnt_w),
        .busy(busy_w), .done(done_w),
        .rd_en(rd_en), .rd_idx(rd_idx),
        .imem_we(imem_we), .imem_addr(imem_addr)
    );

    boot_copy_sram #(
        .DEPTH(MEM_DEPTH), .DW(WORD_W)
    ) u_sram (
        .clk(clk),
        .h_we(host_wr && mem_hit), .h_re(host_rd && mem_hit),
        .h_idx(host_addr[MEM_IW+1:2]), .h_wdata(host_wdata),
        .h_rdata(mem_h_out),
        .e_re(rd_en), .e_idx(rd_idx), .e_rdata(imem_wdata)
    );

    assign host_rdata = rd_from_mem ? mem_h_out : rd_word;
endmodule

// File: rtl/boot_copy_checker.sv
module boot_copy_checker #(
    parameter int unsigned SRC_W = 10,
    parameter int unsigned DST_W = 16,
    parameter int unsigned CNT_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             imem_we,
    input logic [DST_W-1:0] imem_addr,
    input logic [SRC_W-1:0] src,
    input logic [DST_W-1:0] dst,
    input logic [CNT_W-1:0] cnt
);
    logic [CNT_W:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    seen_q <= '0;
        else if (busy) seen_q <= seen_q + (CNT_W+1)'(imem_we);
        else           seen_q <= '0;
    end

    AST_WR_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        imem_we |-> busy); // R1
    AST_WR_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        imem_we && $past(imem_we) |-> imem_addr == $past(imem_addr) + DST_W'(4)); // R1
    AST_WR_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> seen_q == (CNT_W+1)'(cnt)); // R1
    AST_FINISH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R3
    AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !done); // R3
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(src) && $stable(dst) && $stable(cnt)); // R7
endmodule

bind boot_copy_engine boot_copy_checker #(
    .SRC_W(SRC_W), .DST_W(IMEM_AW), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy_w), .done(done_w),
    .imem_we(imem_we), .imem_addr(imem_addr),
    .src(src_w), .dst(dst_w), .cnt(cnt_w)
);

// File: tb/boot_copy_engine_test.sv
module boot_copy_engine_test;
    localparam int unsigned AW = 16;
    localparam int unsigned NV = 6;
    // {src byte offset, dst byte address, word count}
    localparam logic [34:0] VEC [NV] = '{
        {10'h000, 16'h0000, 9'd4},
        {10'h010, 16'h0100, 9'd1},
        {10'h3F8, 16'h2000, 9'd5},
        {10'h040, 16'hFFF8, 9'd3},
        {10'h100, 16'h0400, 9'd16},
        {10'h080, 16'h0500, 9'd0}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic host_wr = 1'b0, host_rd = 1'b0, pwr_up = 1'b0;
    logic [11:0] host_addr = '0;
    logic [31:0] host_wdata = '0, host_rdata, imem_wdata;
    logic imem_we, load_req;
    logic [AW-1:0] imem_addr;

    int checks = 0, errors = 0, cyc = 0, wr_n = 0;
    logic [AW-1:0] log_a [64];
    logic [31:0]   log_d [64];
    int            log_c [64];

    boot_copy_engine uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .pwr_up(pwr_up), .imem_we(imem_we), .imem_addr(imem_addr),
        .imem_wdata(imem_wdata), .load_req(load_req)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (imem_we) begin
        if (wr_n < 64) begin
            log_a[wr_n] = imem_addr; log_d[wr_n] = imem_wdata; log_c[wr_n] = cyc;
        end
        wr_n = wr_n + 1;
    end

    function automatic logic [31:0] pat(int i);
        logic [7:0] b;
        b = i[7:0];
        return {b ^ 8'h5A, ~b, b + 8'h11, 8'hC3};
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic pulse();
        pwr_up = 1'b1;
        @(negedge clk);
        pwr_up = 1'b0;
    endtask

    task automatic check_log(int n, int s, int d, int c0, string tag);
        chk(wr_n == n, tag, 32'(wr_n), 32'(n));
        for (int k = 0; k < n && k < 64; k++) begin
            chk(log_a[k] == AW'(d + 4*k), tag, 32'(log_a[k]), 32'(AW'(d + 4*k)));
            chk(log_d[k] == pat((s/4 + k) % 256), tag, log_d[k], pat((s/4 + k) % 256));
            chk(log_c[k] == c0 + 1 + k, tag, 32'(log_c[k]), 32'(c0 + 1 + k));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        rd(12'h000, v); chk(v == 0, "R10 ctrl after reset", v, 0);
        rd(12'h010, v); chk(v == 0, "R10 status after reset", v, 0);
        chk(load_req == 1'b0, "R9 load_req after reset", 32'(load_req), 0);

        // R8: fill local memory, read some back
        for (int i = 0; i < 256; i++) wr(12'(12'h400 + 4*i), pat(i));
        rd(12'h400, v); chk(v == pat(0), "R8 mem word 0", v, pat(0));
        rd(12'h7FC, v); chk(v == pat(255), "R8 mem word 255", v, pat(255));
        rd(12'h414, v); chk(v == pat(5), "R8 R11 mem word 5", v, pat(5));

        // R1 R2 R3 R4: table of copies started by the go bit
        for (int t = 0; t < NV; t++) begin
            int s, d, n;
            s = int'(VEC[t][34:25]); d = int'(VEC[t][24:9]); n = int'(VEC[t][8:0]);
            wr(12'h004, 32'(s)); wr(12'h008, 32'(d)); wr(12'h00C, 32'(n));
            rd(12'h004, v); chk(v == 32'(s), "R7 src accepted idle", v, 32'(s));
            wr_n = 0;
            wr(12'h000, 32'h8000_0000);
            c0 = cyc;
            if (n == 0) begin
                rd(12'h010, v); chk(v == 1, "R4 zero count done", v, 1);
                rd(12'h000, v); chk(v[31] == 1'b0, "R4 zero count go bit", v, 0);
                chk(wr_n == 0, "R4 zero count writes", 32'(wr_n), 0);
            end else begin
                repeat (n) @(negedge clk);
                rd(12'h000, v); chk(v[31] == 1'b1, "R2 busy at last edge", v, 32'h8000_0000);
                rd(12'h010, v); chk(v == 1, "R3 done after copy", v, 1);
                rd(12'h000, v); chk(v[31] == 1'b0, "R2 go cleared", v, 0);
                check_log(n, s, d, c0, "R1 copy write");
            end
        end

        // R5 R6 R7: armed replay, mid-copy writes and pulse dropped
        wr(12'h004, 32'h020); wr(12'h008, 32'h3000); wr(12'h00C, 32'd8);
        wr(12'h000, 32'h4000_0000);
        rd(12'h000, v); chk(v == 32'h4000_0000, "R2 arm readback", v, 32'h4000_0000);
        wr_n = 0;
        pulse();
        c0 = cyc;
        wr(12'h004, 32'h100); wr(12'h008, 32'h0); wr(12'h00C, 32'd3);
        pulse();
        wr(12'h000, 32'hC000_0000);
        rd(12'h004, v); chk(v == 32'h020, "R7 src held busy", v, 32'h020);
        rd(12'h008, v); chk(v == 32'h3000, "R7 dst held busy", v, 32'h3000);
        rd(12'h00C, v); chk(v == 32'd8, "R7 cnt held busy", v, 8);
        repeat (12) @(negedge clk);
        check_log(8, 32'h020, 32'h3000, c0, "R5 R6 armed copy");
        rd(12'h010, v); chk(v == 1, "R3 done armed copy", v, 1);
        wr(12'h00C, 32'd2);
        rd(12'h00C, v); chk(v == 2, "R7 cnt accepted idle", v, 2);
        wr_n = 0;
        pulse();
        c0 = cyc;
        repeat (6) @(negedge clk);
        check_log(2, 32'h020, 32'h3000, c0, "R5 second replay");
        wr(12'h000, 32'h0);
        wr_n = 0;
        pulse();
        repeat (6) @(negedge clk);
        chk(wr_n == 0, "R5 disarmed pulse ignored", 32'(wr_n), 0);

        // R9: pointer and size registers
        wr(12'h090, 32'h1234_5670); wr(12'h098, 32'hABCD_0010);
        wr(12'h09C, 32'h0000_0800); wr(12'h094, 32'h8000_0400);
        rd(12'h090, v); chk(v == 32'h1234_5670, "R9 prog pointer", v, 32'h1234_5670);
        rd(12'h094, v); chk(v == 32'h8000_0400, "R9 prog size", v, 32'h8000_0400);
        rd(12'h098, v); chk(v == 32'hABCD_0010, "R9 data pointer", v, 32'hABCD_0010);
        rd(12'h09C, v); chk(v == 32'h0000_0800, "R9 data size", v, 32'h800);
        chk(load_req == 1'b1, "R9 load_req set", 32'(load_req), 1);
        wr(12'h094, 32'h0000_0400);
        chk(load_req == 1'b0, "R9 load_req clear", 32'(load_req), 0);

        // R8 R10: reset keeps memory, clears arm/status
        wr(12'h000, 32'h4000_0000);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(12'h414, v); chk(v == pat(5), "R8 mem kept over reset", v, pat(5));
        rd(12'h000, v); chk(v == 0, "R10 ctrl cleared", v, 0);
        rd(12'h010, v); chk(v == 0, "R10 status cleared", v, 0);
        rd(12'h00C, v); chk(v == 0, "R10 count cleared", v, 0);
        wr_n = 0;
        pulse();
        repeat (4) @(negedge clk);
        chk(wr_n == 0, "R10 arm cleared", 32'(wr_n), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule